// File: doc/BRIEF.md
# Flash Access Violation Detector

This block sits beside the CPU and watches every access the core makes to on-chip program flash. There are three kinds of access: instruction fetches (which include branch targets), table reads of code space, and data-space writes that reach flash because the flash write-enable control is set. Each cycle the block tests the presented accesses against a set of rules. When any access breaks a rule, it requests a system reset.

Every address is compared against one movable limit, the lock-byte address. An address strictly greater than the limit is outside user code space. Flash writes and erases have one more condition: the supply monitor must be enabled. A security verdict comes in already decoded as a single bit. When that bit is set, it forbids whatever flash access is presented in the same cycle. The block does not model the flash array, its timing or its programming sequencer.

The output is registered. It is high for one clock after each cycle that held an illegal access. If one cycle breaks several rules at once, the block still gives a single pulse.

Top module: `flash_guard`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `reset_req` is 0, whatever the other inputs hold.
- R2: A cycle with `fetch_vld`=1 and `fetch_addr` > `lock_addr` (unsigned) drives `reset_req` to 1 in the next cycle.
- R3: A cycle with `tread_vld`=1 and `tread_addr` > `lock_addr` drives `reset_req` to 1 in the next cycle.
- R4: A flash write is a cycle with `xwr_vld`=1, `flash_wen`=1 and `erase_mode`=0. A flash write with `xwr_addr` > `lock_addr` drives `reset_req` to 1 in the next cycle.
- R5: A flash erase is a cycle with `xwr_vld`=1, `flash_wen`=1 and `erase_mode`=1. A flash erase with `xwr_addr` > `lock_addr` drives `reset_req` to 1 in the next cycle.
- R6: A flash write or erase in a cycle where `vmon_en`=0 drives `reset_req` to 1 in the next cycle, at any address.
- R7: A data-space write with `flash_wen`=0 goes to RAM. The block ignores it whatever its address, `erase_mode`, `vmon_en` or `sec_deny`, so `reset_req` stays 0 in the next cycle.
- R8: If `sec_deny`=1 in a cycle that presents a fetch, a table read or a flash write/erase, `reset_req` is 1 in the next cycle. If `sec_deny`=1 in a cycle with no flash access, it has no effect.
- R9: An address equal to `lock_addr` is legal for every kind of access.
- R10: A cycle that breaks several rules at once gives one pulse. If the following cycle is legal, `reset_req` is high for exactly that one clock.
- R11: `reset_req` is 0 in the cycle after any cycle that held no illegal access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_vld | input | 1 | Instruction fetch or branch target presented |
| fetch_addr | input | 17 | Fetch address |
| tread_vld | input | 1 | Code-space table read presented |
| tread_addr | input | 17 | Table-read address |
| xwr_vld | input | 1 | Data-space write presented |
| xwr_addr | input | 17 | Data-space write address |
| flash_wen | input | 1 | Flash write-enable control (0 routes writes to RAM) |
| erase_mode | input | 1 | Flash operation is an erase when 1 |
| lock_addr | input | 17 | Lock-byte address; the highest legal address |
| sec_deny | input | 1 | Decoded security verdict forbidding the current flash access |
| vmon_en | input | 1 | Supply monitor enabled |
| reset_req | output | 1 | One-clock system reset request |

## Verification
The hardest situations to reach from the ports are the narrow boundaries. One is an address exactly at the lock byte, or one above it, while the lock itself has moved. The other is a cycle where a harmless RAM write coincides with a security denial or a disabled supply monitor. Random stimulus almost never lands on these cases.

The stimulus therefore draws each address as the current lock value plus an offset of -1, 0 or +1 most of the time, and only sometimes as a free value. The lock, the write-enable, the erase, the security and the monitor controls are re-drawn every cycle. Directed steps come first and pin each boundary and each overlap of rules. Two consecutive illegal cycles followed by a legal one confirm the width of the pulse.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

    localparam int FG_ADDR_W = 17;
    localparam int FG_N_SRC  = 3;

    typedef enum logic [1:0] {
        SRC_FETCH = 2'd0,
        SRC_TREAD = 2'd1,
        SRC_XWR   = 2'd2
    } src_e;

    typedef struct packed {
        logic fetch_hi;
        logic tread_hi;
        logic write_hi;
        logic erase_hi;
        logic prog_nosupply;
        logic sec_block;
    } viol_t;

    function automatic logic any_viol(viol_t v);
        return |v;
    endfunction

endpackage

// File: rtl/fg_bound_cmp.sv
module fg_bound_cmp #(
    parameter int W = 17
) (
    input  logic         vld,
    input  logic [W-1:0] addr,
    input  logic [W-1:0] lim,
    output logic         hit
);
    always_comb begin
        hit = vld && (addr > lim);
    end

    always_comb begin
        if (vld && (addr == lim)) begin
            a_equal_legal_r9: assert (!hit) else $error("R9 equal address flagged");
        end
    end
endmodule

// File: rtl/fg_rule_eval.sv
module fg_rule_eval
    import flash_guard_pkg::*;
#(
    parameter int N_SRC = FG_N_SRC
) (
    input  logic [N_SRC-1:0] hit,
    input  logic             fetch_vld,
    input  logic             tread_vld,
    input  logic             xwr_vld,
    input  logic             flash_wen,
    input  logic             erase_mode,
    input  logic             vmon_en,
    input  logic             sec_deny,
    output viol_t            viol
);
    logic prog_op;
    logic any_access;

    always_comb begin
        prog_op    = xwr_vld && flash_wen;
        any_access = fetch_vld || tread_vld || prog_op;

        viol               = '0;
        viol.fetch_hi      = hit[SRC_FETCH];
        viol.tread_hi      = hit[SRC_TREAD];
        viol.write_hi      = prog_op && !erase_mode && hit[SRC_XWR];
        viol.erase_hi      = prog_op &&  erase_mode && hit[SRC_XWR];
        viol.prog_nosupply = prog_op && !vmon_en;
        viol.sec_block     = sec_deny && any_access;
    end

    always_comb begin
        if (xwr_vld && !flash_wen && !fetch_vld && !tread_vld) begin
            a_ram_write_clean_r7: assert (viol == '0) else $error("R7 RAM write flagged");
        end
    end
endmodule

// File: rtl/fg_pulse.sv
module fg_pulse
    import flash_guard_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  viol_t viol,
    output logic  pulse
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pulse <= 1'b0;
        end else begin
            pulse <= any_viol(viol);
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk) rst |=> !pulse);
endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W = FG_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_vld,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              tread_vld,
    input  logic [ADDR_W-1:0] tread_addr,
    input  logic              xwr_vld,
    input  logic [ADDR_W-1:0] xwr_addr,
    input  logic              flash_wen,
    input  logic              erase_mode,
    input  logic [ADDR_W-1:0] lock_addr,
    input  logic              sec_deny,
    input  logic              vmon_en,
    output logic              reset_req
);
    localparam int N_SRC = FG_N_SRC;

    logic [ADDR_W-1:0] src_addr [N_SRC];
    logic [N_SRC-1:0]  src_vld;
    logic [N_SRC-1:0]  src_hit;
    viol_t             viol;

    always_comb begin
        src_addr[SRC_FETCH] = fetch_addr;
        src_addr[SRC_TREAD] = tread_addr;
        src_addr[SRC_XWR]   = xwr_addr;
        src_vld[SRC_FETCH]  = fetch_vld;
        src_vld[SRC_TREAD]  = tread_vld;
        src_vld[SRC_XWR]    = xwr_vld;
    end

    for (genvar g = 0; g < N_SRC; g++) begin : g_cmp
        fg_bound_cmp #(.W(ADDR_W)) u_cmp (
            .vld  (src_vld[g]),
            .addr (src_addr[g]),
            .lim  (lock_addr),
            .hit  (src_hit[g])
        );
    end

    fg_rule_eval #(.N_SRC(N_SRC)) u_rules (
        .hit        (src_hit),
        .fetch_vld  (fetch_vld),
        .tread_vld  (tread_vld),
        .xwr_vld    (xwr_vld),
        .flash_wen  (flash_wen),
        .erase_mode (erase_mode),
        .vmon_en    (vmon_en),
        .sec_deny   (sec_deny),
        .viol       (viol)
    );

    fg_pulse u_pulse (
        .clk   (clk),
        .rst   (rst),
        .viol  (viol),
        .pulse (reset_req)
    );

    p_fetch_hi_r2: assert property (@(posedge clk) disable iff (rst)
        (fetch_vld && fetch_addr > lock_addr) |=> reset_req);
    p_tread_hi_r3: assert property (@(posedge clk) disable iff (rst)
        (tread_vld && tread_addr > lock_addr) |=> reset_req);
    p_write_hi_r4: assert property (@(posedge clk) disable iff (rst)
        (xwr_vld && flash_wen && !erase_mode && xwr_addr > lock_addr) |=> reset_req);
    p_erase_hi_r5: assert property (@(posedge clk) disable iff (rst)
        (xwr_vld && flash_wen && erase_mode && xwr_addr > lock_addr) |=> reset_req);
    p_nosupply_r6: assert property (@(posedge clk) disable iff (rst)
        (xwr_vld && flash_wen && !vmon_en) |=> reset_req);
    p_sec_block_r8: assert property (@(posedge clk) disable iff (rst)
        (sec_deny && (fetch_vld || tread_vld || (xwr_vld && flash_wen))) |=> reset_req);
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (!fetch_vld && !tread_vld && !(xwr_vld && flash_wen)) |=> !reset_req);
endmodule

// File: tb/sim_flash_guard.sv
module sim_flash_guard;
    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst;
    logic          fetch_vld, tread_vld, xwr_vld;
    logic [AW-1:0] fetch_addr, tread_addr, xwr_addr, lock_addr;
    logic          flash_wen, erase_mode, sec_deny, vmon_en;
    logic          reset_req;

    int n_checks = 0;
    int n_errors = 0;
    bit exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    flash_guard u0 (
        .clk(clk), .rst(rst),
        .fetch_vld(fetch_vld), .fetch_addr(fetch_addr),
        .tread_vld(tread_vld), .tread_addr(tread_addr),
        .xwr_vld(xwr_vld), .xwr_addr(xwr_addr),
        .flash_wen(flash_wen), .erase_mode(erase_mode),
        .lock_addr(lock_addr), .sec_deny(sec_deny), .vmon_en(vmon_en),
        .reset_req(reset_req)
    );

    function automatic bit model();
        bit bad = 0;
        bit prog = xwr_vld && flash_wen;
        if (rst) return 0;
        if (fetch_vld && int'(fetch_addr) > int'(lock_addr)) bad = 1;
        if (tread_vld && int'(tread_addr) > int'(lock_addr)) bad = 1;
        if (prog && int'(xwr_addr) > int'(lock_addr)) bad = 1;
        if (prog && !vmon_en) bad = 1;
        if (sec_deny && (fetch_vld || tread_vld || prog)) bad = 1;
        return bad;
    endfunction

    task automatic cyc(string tag);
        bit e;
        string t;
        exp_q.push_back(model());
        tag_q.push_back(tag);
        @(negedge clk);
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_checks++;
        if (reset_req !== e) begin
            n_errors++;
            $display("FAIL %s: reset_req=%0b expected %0b", t, reset_req, e);
        end
    endtask

    task automatic idle();
        fetch_vld = 0; tread_vld = 0; xwr_vld = 0;
        fetch_addr = '0; tread_addr = '0; xwr_addr = '0;
        flash_wen = 0; erase_mode = 0; sec_deny = 0; vmon_en = 1;
    endtask

    function automatic logic [AW-1:0] near(logic [AW-1:0] l);
        int r = $urandom_range(0, 9);
        if (r < 3) return l - 1;
        if (r < 6) return l;
        if (r < 9) return l + 1;
        return AW'($urandom);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        idle();
        lock_addr = 17'h1FBFF;
        rst = 1;
        fetch_vld = 1; fetch_addr = '1; sec_deny = 1;
        @(negedge clk);
        cyc("R1");
        cyc("R1");
        rst = 0; idle();
        cyc("R1");

        fetch_vld = 1; fetch_addr = lock_addr + 1; cyc("R2");
        idle(); cyc("R11");
        fetch_vld = 1; fetch_addr = lock_addr; cyc("R9");
        idle(); tread_vld = 1; tread_addr = lock_addr + 1; cyc("R3");
        tread_addr = lock_addr; cyc("R9");
        idle(); xwr_vld = 1; flash_wen = 1; xwr_addr = lock_addr + 1; cyc("R4");
        xwr_addr = lock_addr; cyc("R9");
        erase_mode = 1; xwr_addr = lock_addr + 5; cyc("R5");
        xwr_addr = lock_addr; cyc("R9");
        xwr_addr = 17'h00010; vmon_en = 0; cyc("R6");
        erase_mode = 0; cyc("R6");
        flash_wen = 0; xwr_addr = '1; erase_mode = 1; sec_deny = 1; cyc("R7");
        vmon_en = 1; cyc("R7");
        idle(); sec_deny = 1; cyc("R8");
        tread_vld = 1; tread_addr = 17'h00100; cyc("R8");
        idle(); cyc("R11");
        lock_addr = 17'h00FFF;
        fetch_vld = 1; fetch_addr = 17'h01000; tread_vld = 1; tread_addr = 17'h1FFFF;
        xwr_vld = 1; flash_wen = 1; xwr_addr = 17'h1F000; vmon_en = 0; sec_deny = 1;
        cyc("R10");
        idle(); cyc("R10");
        fetch_vld = 1; fetch_addr = 17'h01000; cyc("R10");
        cyc("R10");
        idle(); cyc("R10");
        lock_addr = 17'h00000; fetch_vld = 1; fetch_addr = 17'h00000; cyc("R9");
        fetch_addr = 17'h00001; cyc("R2");
        idle(); cyc("R11");

        for (int i = 0; i < 4000; i++) begin
            lock_addr  = AW'($urandom);
            fetch_vld  = 1'($urandom);
            tread_vld  = 1'($urandom);
            xwr_vld    = 1'($urandom);
            fetch_addr = near(lock_addr);
            tread_addr = near(lock_addr);
            xwr_addr   = near(lock_addr);
            flash_wen  = 1'($urandom);
            erase_mode = 1'($urandom);
            sec_deny   = ($urandom_range(0, 7) == 0);
            vmon_en    = ($urandom_range(0, 5) != 0);
            rst        = ($urandom_range(0, 199) == 0);
            cyc(rst ? "R1" : "R10");
        end
        rst = 0; idle(); cyc("R11");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule